// File: doc/BRIEF.md
# FIFO DMA Request Generator

This block decides when a serial-bus controller should ask its DMA engine to move data into its transmit FIFO or out of its receive FIFO. Each FIFO is given to either the master side or the slave side of the controller. The block watches the FIFO fill levels and then raises two lines towards the DMA engine. The single-request line asks for one byte. The burst-request line says a block of bytes can be moved in one go.

On the master side, a burst command loads a remaining-byte counter from the programmed length. Every byte that moves between the DMA engine and a master-owned FIFO lowers that counter. When the counter is empty, no master request is raised until the next burst command. Master receive uses a fixed threshold of four bytes for burst requests. The slave side compares against programmable trigger levels. For slave transmit, the single request is raised when the remote bus master strobes for the next byte.

Both request lines come from flops, and they are evaluated again on every clock. A global DMA enable forces both lines low. FIFO service is then left to interrupts.

Top module: `fifo_dma_req_gen`

## Requirements
- R1: A `burst_go` pulse loads `burst_left` from `burst_len`, visible one cycle later. A load wins over a decrement in the same cycle. Otherwise `burst_left` drops by one for each byte moved on a master-owned FIFO: `rx_pop` with `rx_to_slave`=0, and `tx_push` with `tx_to_slave`=0. Two such bytes in one cycle drop it by two. It never goes below zero.
- R2: Master requests are held low from the clock edge at which `burst_left` becomes zero, and stay low until a new `burst_go`.
- R3: Master receive (`m_rx_en`=1, receive FIFO owned by the master) raises `dma_sreq` when `rx_lvl` is at least 1, and keeps it low while the FIFO is empty.
- R4: Master receive raises `dma_breq` when `rx_lvl` is 4 or more, and not when it is 3.
- R5: Master transmit (`m_tx_en`=1, transmit FIFO owned by the master) raises `dma_sreq` while `tx_lvl` is below the FIFO depth. It raises `dma_breq` while the free space, the depth minus `tx_lvl`, is 4 or more.
- R6: Slave transmit (`s_tx_en`=1, `tx_to_slave`=1) raises `dma_sreq` from the cycle after a `s_byte_req` strobe. The request holds until a `tx_push` is seen.
- R7: Slave transmit raises `dma_breq` while `tx_lvl` < `tx_trig`.
- R8: Slave receive (`s_rx_en`=1, `rx_to_slave`=1) raises `dma_sreq` whenever `rx_lvl` is nonzero.
- R9: Slave receive raises `dma_breq` only when `rx_lvl` > `rx_trig`.
- R10: With `dma_en`=0, both request outputs are low one cycle later.
- R11: The outputs are registered. A request that loses its condition falls exactly one cycle after the input change.
- R12: A role that does not own a FIFO raises no request for that FIFO. Its byte moves do not change `burst_left`.
- R13: A synchronous active-high `rst` clears `burst_left` and both request outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dma_en | input | 1 | Global DMA request enable |
| m_tx_en | input | 1 | Master transmit DMA enable |
| m_rx_en | input | 1 | Master receive DMA enable |
| s_tx_en | input | 1 | Slave transmit-FIFO DMA enable |
| s_rx_en | input | 1 | Slave receive-FIFO DMA enable |
| tx_to_slave | input | 1 | 1: transmit FIFO owned by slave, 0: by master |
| rx_to_slave | input | 1 | 1: receive FIFO owned by slave, 0: by master |
| burst_len | input | LEN_W | Programmed master burst length in bytes |
| burst_go | input | 1 | Master burst command pulse |
| tx_lvl | input | LVL_W | Transmit FIFO fill level |
| rx_lvl | input | LVL_W | Receive FIFO fill level |
| tx_trig | input | LVL_W | Slave transmit trigger level |
| rx_trig | input | LVL_W | Slave receive trigger level |
| s_byte_req | input | 1 | Strobe: remote master asks for the next byte |
| tx_push | input | 1 | DMA wrote one byte into the transmit FIFO |
| rx_pop | input | 1 | DMA read one byte from the receive FIFO |
| dma_sreq | output | 1 | Single-byte DMA request |
| dma_breq | output | 1 | Burst DMA request |
| burst_left | output | LEN_W | Remaining master burst bytes |

## Verification
On every cycle, the assertions check these points: the counter load and the rule that it never rises, master silence while the counter is zero, the master-receive burst threshold, the slave-receive trigger comparison, slave-transmit pending rising only after a strobe, and the global disable. Some behaviour needs a stimulus history, and only the bench scenarios can show it. This covers the strobe-to-push hold of slave transmit, the two-byte decrement, clamping at zero, the return of requests after a new burst command, and the exact boundaries of each threshold. The bench also compares every output on every clock against a behavioural model.

// File: rtl/fdr_pkg.sv
package fdr_pkg;

  // Threshold test on fill levels; kept here so the bench restates it on its own.
  function automatic logic lvl_at_least(input int lvl, input int thr);
    return lvl >= thr;
  endfunction

  // Free entries left in a FIFO of the given depth.
  function automatic int free_slots(input int depth, input int lvl);
    return (lvl >= depth) ? 0 : depth - lvl;
  endfunction

  // Next value of a down counter with load priority and clamping at zero.
  function automatic int next_count(input int cur, input int len, input logic load, input int dec);
    if (load) return len;
    return (cur > dec) ? cur - dec : 0;
  endfunction

endpackage

// File: rtl/fdr_burst_counter.sv
module fdr_burst_counter #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [LEN_W-1:0] len,
  input  logic             dec_rx,
  input  logic             dec_tx,
  output logic [LEN_W-1:0] cnt_q,
  output logic             live
);
  import fdr_pkg::*;

  logic [LEN_W-1:0] cnt_d;
  int               dec_n;

  always_comb begin
    dec_n = int'(dec_rx) + int'(dec_tx);
    cnt_d = LEN_W'(next_count(int'(cnt_q), int'(len), load, dec_n));
  end

  // Gate on the next value so requests fall on the same edge the count empties.
  assign live = (cnt_d != '0);

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  p_load_r1: assert property (@(posedge clk) disable iff (rst)
    load |=> cnt_q == $past(len));

  p_no_rise_r1: assert property (@(posedge clk) disable iff (rst)
    !load |=> cnt_q <= $past(cnt_q));

endmodule

// File: rtl/fdr_master_req.sv
module fdr_master_req #(
  parameter int LVL_W     = 4,
  parameter int DEPTH     = 8,
  parameter int RX_THR    = 4,
  parameter int TX_THR    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dma_en,
  input  logic             rx_en,
  input  logic             tx_en,
  input  logic             rx_own,
  input  logic             tx_own,
  input  logic             live,
  input  logic [LVL_W-1:0] rx_lvl,
  input  logic [LVL_W-1:0] tx_lvl,
  output logic             sreq_q,
  output logic             breq_q
);
  import fdr_pkg::*;

  logic rx_ok, tx_ok;
  logic rx_s, rx_b, tx_s, tx_b;

  always_comb begin
    rx_ok = dma_en && rx_en && rx_own && live;
    tx_ok = dma_en && tx_en && tx_own && live;
    rx_s  = rx_ok && lvl_at_least(int'(rx_lvl), 1);
    rx_b  = rx_ok && lvl_at_least(int'(rx_lvl), RX_THR);
    tx_s  = tx_ok && (free_slots(DEPTH, int'(tx_lvl)) > 0);
    tx_b  = tx_ok && lvl_at_least(free_slots(DEPTH, int'(tx_lvl)), TX_THR);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sreq_q <= 1'b0;
      breq_q <= 1'b0;
    end else begin
      sreq_q <= rx_s || tx_s;
      breq_q <= rx_b || tx_b;
    end
  end

  p_rx_thr_r4: assert property (@(posedge clk) disable iff (rst)
    (breq_q && !$past(tx_en && tx_own)) |-> int'($past(rx_lvl)) >= RX_THR);

  p_dead_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(live) |-> (!sreq_q && !breq_q));

endmodule

// File: rtl/fdr_slave_req.sv
module fdr_slave_req #(
  parameter int LVL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dma_en,
  input  logic             rx_en,
  input  logic             tx_en,
  input  logic             rx_own,
  input  logic             tx_own,
  input  logic             byte_req,
  input  logic             tx_push,
  input  logic [LVL_W-1:0] rx_lvl,
  input  logic [LVL_W-1:0] tx_lvl,
  input  logic [LVL_W-1:0] rx_trig,
  input  logic [LVL_W-1:0] tx_trig,
  output logic             sreq_q,
  output logic             breq_q
);
  import fdr_pkg::*;

  logic rx_ok, tx_ok, pend_q, pend_d;
  logic rx_s, rx_b, tx_s, tx_b;

  always_comb begin
    rx_ok  = dma_en && rx_en && rx_own;
    tx_ok  = dma_en && tx_en && tx_own;
    pend_d = tx_ok && (byte_req || (pend_q && !tx_push));
    tx_s   = pend_d;
    tx_b   = tx_ok && (tx_lvl < tx_trig);
    rx_s   = rx_ok && lvl_at_least(int'(rx_lvl), 1);
    rx_b   = rx_ok && (rx_lvl > rx_trig);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      sreq_q <= 1'b0;
      breq_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      sreq_q <= rx_s || tx_s;
      breq_q <= rx_b || tx_b;
    end
  end

  p_rx_trig_r9: assert property (@(posedge clk) disable iff (rst)
    (breq_q && !$past(tx_en && tx_own)) |-> $past(rx_lvl) > $past(rx_trig));

  p_pend_src_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(pend_q) |-> $past(byte_req));

endmodule

// File: rtl/fifo_dma_req_gen.sv
module fifo_dma_req_gen #(
  parameter int FIFO_DEPTH = 8,
  parameter int LEN_W      = 8,
  parameter int MRX_THR    = 4,
  parameter int MTX_THR    = 4,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dma_en,
  input  logic             m_tx_en,
  input  logic             m_rx_en,
  input  logic             s_tx_en,
  input  logic             s_rx_en,
  input  logic             tx_to_slave,
  input  logic             rx_to_slave,
  input  logic [LEN_W-1:0] burst_len,
  input  logic             burst_go,
  input  logic [LVL_W-1:0] tx_lvl,
  input  logic [LVL_W-1:0] rx_lvl,
  input  logic [LVL_W-1:0] tx_trig,
  input  logic [LVL_W-1:0] rx_trig,
  input  logic             s_byte_req,
  input  logic             tx_push,
  input  logic             rx_pop,
  output logic             dma_sreq,
  output logic             dma_breq,
  output logic [LEN_W-1:0] burst_left
);

  logic live;
  logic m_sreq, m_breq, s_sreq, s_breq;
  logic m_rx_move, m_tx_move;

  assign m_rx_move = rx_pop  && !rx_to_slave;
  assign m_tx_move = tx_push && !tx_to_slave;

  fdr_burst_counter #(.LEN_W(LEN_W)) u_cnt (
    .clk(clk), .rst(rst), .load(burst_go), .len(burst_len),
    .dec_rx(m_rx_move), .dec_tx(m_tx_move),
    .cnt_q(burst_left), .live(live)
  );

  fdr_master_req #(.LVL_W(LVL_W), .DEPTH(FIFO_DEPTH), .RX_THR(MRX_THR), .TX_THR(MTX_THR)) u_mst (
    .clk(clk), .rst(rst), .dma_en(dma_en), .rx_en(m_rx_en), .tx_en(m_tx_en),
    .rx_own(!rx_to_slave), .tx_own(!tx_to_slave), .live(live),
    .rx_lvl(rx_lvl), .tx_lvl(tx_lvl), .sreq_q(m_sreq), .breq_q(m_breq)
  );

  fdr_slave_req #(.LVL_W(LVL_W)) u_slv (
    .clk(clk), .rst(rst), .dma_en(dma_en), .rx_en(s_rx_en), .tx_en(s_tx_en),
    .rx_own(rx_to_slave), .tx_own(tx_to_slave), .byte_req(s_byte_req),
    .tx_push(tx_push), .rx_lvl(rx_lvl), .tx_lvl(tx_lvl),
    .rx_trig(rx_trig), .tx_trig(tx_trig), .sreq_q(s_sreq), .breq_q(s_breq)
  );

  assign dma_sreq = m_sreq || s_sreq;
  assign dma_breq = m_breq || s_breq;

  p_zero_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (burst_left == '0) |-> (!m_sreq && !m_breq));

  p_dma_off_r10: assert property (@(posedge clk) disable iff (rst)
    !dma_en |=> (!dma_sreq && !dma_breq));

  p_reset_r13: assert property (@(posedge clk)
    rst |=> (!dma_sreq && !dma_breq && burst_left == '0));

endmodule

// File: tb/sim_fifo_dma_req_gen.sv
`timescale 1ns/1ps
module sim_fifo_dma_req_gen;
  localparam int DEPTH = 8;
  localparam int LW    = 8;
  localparam int VW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dma_en = 0, m_tx_en = 0, m_rx_en = 0, s_tx_en = 0, s_rx_en = 0;
  logic tx_to_slave = 1, rx_to_slave = 1;
  logic [LW-1:0] burst_len = '0;
  logic burst_go = 0, s_byte_req = 0, tx_push = 0, rx_pop = 0;
  logic [VW-1:0] tx_lvl = '0, rx_lvl = '0, tx_trig = '0, rx_trig = '0;
  logic dma_sreq, dma_breq;
  logic [LW-1:0] burst_left;

  int checks = 0, errors = 0, cycles = 0;
  bit started = 0;

  always #2.5 clk = ~clk;

  fifo_dma_req_gen #(.FIFO_DEPTH(DEPTH), .LEN_W(LW)) u0 (
    .clk(clk), .rst(rst), .dma_en(dma_en), .m_tx_en(m_tx_en), .m_rx_en(m_rx_en),
    .s_tx_en(s_tx_en), .s_rx_en(s_rx_en), .tx_to_slave(tx_to_slave),
    .rx_to_slave(rx_to_slave), .burst_len(burst_len), .burst_go(burst_go),
    .tx_lvl(tx_lvl), .rx_lvl(rx_lvl), .tx_trig(tx_trig), .rx_trig(rx_trig),
    .s_byte_req(s_byte_req), .tx_push(tx_push), .rx_pop(rx_pop),
    .dma_sreq(dma_sreq), .dma_breq(dma_breq), .burst_left(burst_left)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_req(input string tag, input int s, input int b);
    chk(int'(dma_sreq) == s, tag, int'(dma_sreq), s);
    chk(int'(dma_breq) == b, tag, int'(dma_breq), b);
  endtask

  // Behavioural reference model
  int  mdl_cnt = 0;
  bit  mdl_pend = 0, mdl_s = 0, mdl_b = 0;
  always @(posedge clk) begin
    int nc, mv, tfree;
    bit alive, mr, mt, sr, st, np;
    started <= 1;
    if (rst) begin
      mdl_cnt <= 0; mdl_pend <= 0; mdl_s <= 0; mdl_b <= 0;
    end else begin
      mv = 0;
      if (rx_pop && !rx_to_slave) mv++;
      if (tx_push && !tx_to_slave) mv++;
      if (burst_go) nc = int'(burst_len);
      else nc = (mdl_cnt - mv < 0) ? 0 : mdl_cnt - mv;
      alive = nc != 0;
      mr = dma_en && m_rx_en && !rx_to_slave && alive;
      mt = dma_en && m_tx_en && !tx_to_slave && alive;
      sr = dma_en && s_rx_en && rx_to_slave;
      st = dma_en && s_tx_en && tx_to_slave;
      np = st && (s_byte_req || (mdl_pend && !tx_push));
      tfree = DEPTH - int'(tx_lvl);
      mdl_cnt  <= nc;
      mdl_pend <= np;
      mdl_s <= (mr && rx_lvl != 0) || (mt && tfree > 0) || np || (sr && rx_lvl != 0);
      mdl_b <= (mr && int'(rx_lvl) > 3) || (mt && tfree > 3) ||
               (st && tx_lvl < tx_trig) || (sr && rx_lvl > rx_trig);
    end
  end

  always @(negedge clk) begin
    if (started) begin
      chk(int'(dma_sreq) == int'(mdl_s), "R11 model sreq", int'(dma_sreq), int'(mdl_s));
      chk(int'(dma_breq) == int'(mdl_b), "R11 model breq", int'(dma_breq), int'(mdl_b));
      chk(int'(burst_left) == mdl_cnt, "R1 model count", int'(burst_left), mdl_cnt);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 20000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(2);
    rst = 0;
    expect_req("R13 reset", 0, 0);
    chk(burst_left == 0, "R13 reset count", int'(burst_left), 0);

    // Master receive
    dma_en = 1; m_rx_en = 1; rx_to_slave = 0; burst_len = 6; burst_go = 1;
    tick(); burst_go = 0;
    chk(burst_left == 6, "R1 load", int'(burst_left), 6);
    expect_req("R3 empty", 0, 0);
    rx_lvl = 2; tick(); expect_req("R3 data", 1, 0);
    rx_lvl = 4; tick(); expect_req("R4 four", 1, 1);
    rx_lvl = 3; tick(); expect_req("R4 three", 1, 0);
    rx_pop = 1; tick(); chk(burst_left == 5, "R1 dec", int'(burst_left), 5);
    tick(5); chk(burst_left == 0, "R1 drain", int'(burst_left), 0);
    expect_req("R2 zero", 0, 0);
    rx_lvl = 4; tick();
    chk(burst_left == 0, "R1 clamp", int'(burst_left), 0);
    expect_req("R2 stay off", 0, 0);
    rx_pop = 0; burst_len = 3; burst_go = 1; tick(); burst_go = 0;
    expect_req("R2 resume", 1, 1);
    dma_en = 0; tick(); expect_req("R10 off", 0, 0);
    dma_en = 1; tick(); expect_req("R10 on", 1, 1);
    rx_lvl = 0; expect_req("R11 before edge", 1, 1);
    tick(); expect_req("R11 fell", 0, 0);

    // Ownership
    rx_lvl = 4; rx_to_slave = 1; rx_pop = 1; tick(); rx_pop = 0;
    expect_req("R12 rx not master", 0, 0);
    chk(burst_left == 3, "R12 no dec", int'(burst_left), 3);

    // Master transmit
    m_rx_en = 0; tx_to_slave = 0; m_tx_en = 1; tx_lvl = 8; tick();
    expect_req("R5 full", 0, 0);
    tx_lvl = 5; tick(); expect_req("R5 free3", 1, 0);
    tx_lvl = 4; tick(); expect_req("R5 free4", 1, 1);
    rx_to_slave = 0; rx_pop = 1; tx_push = 1; tick(); rx_pop = 0;
    chk(burst_left == 1, "R1 double dec", int'(burst_left), 1);
    tick(); tx_push = 0;
    chk(burst_left == 0, "R1 tx dec", int'(burst_left), 0);
    expect_req("R2 tx zero", 0, 0);
    tx_to_slave = 1; tick(); expect_req("R12 tx not master", 0, 0);

    // Slave transmit
    m_tx_en = 0; rx_to_slave = 1; s_tx_en = 1; tx_trig = 3; tx_lvl = 5; tick();
    expect_req("R6 idle", 0, 0);
    s_byte_req = 1; tick(); s_byte_req = 0;
    expect_req("R6 strobe", 1, 0);
    tick(); expect_req("R6 hold", 1, 0);
    tx_push = 1; tick(); tx_push = 0;
    expect_req("R6 served", 0, 0);
    tx_lvl = 2; tick(); expect_req("R7 below", 0, 1);
    tx_lvl = 3; tick(); expect_req("R7 equal", 0, 0);

    // Slave receive
    s_tx_en = 0; s_rx_en = 1; rx_trig = 2; rx_lvl = 0; tick();
    expect_req("R8 empty", 0, 0);
    rx_lvl = 1; tick(); expect_req("R8 data", 1, 0);
    rx_lvl = 2; tick(); expect_req("R9 equal", 1, 0);
    rx_lvl = 3; tick(); expect_req("R9 above", 1, 1);

    // Reset mid-run
    burst_len = 9; burst_go = 1; tick(); burst_go = 0;
    rst = 1; tick(); rst = 0;
    chk(burst_left == 0, "R13 mid count", int'(burst_left), 0);
    expect_req("R13 mid req", 0, 0);

    tick(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule